// File: doc/BRIEF.md
# LFSR Keyed Stream Scrambler

This block scrambles or unscrambles a serial bit stream with a keystream from an 8-bit maximal-length linear feedback shift register. Software or a neighbouring block loads a seed, which serves as the shared secret. Each cycle in which the input strobe is high, one data bit is XORed with the top bit of the generator, and the generator moves one step. The result appears one cycle later with its own strobe.

Scrambling and unscrambling use the same XOR path. A second instance with the same seed, fed the scrambled stream with the same bit alignment, returns the original bits exactly. The generator uses the polynomial x^8 + x^6 + x^5 + x^4 + 1 in Fibonacci form, which gives a period of 255. The full generator state is also available in parallel, as an 8-bit pseudo-random value.

The output slot is a two-state machine. SLOT_EMPTY means no result is held, and SLOT_FULL means a result is on the output. There are three transitions:
- "accept" goes from SLOT_EMPTY to SLOT_FULL when the input strobe is high.
- "stream" stays in SLOT_FULL while the strobe stays high.
- "drain" goes from SLOT_FULL back to SLOT_EMPTY when the strobe is low.

SLOT_EMPTY also holds while no input arrives.

Top module: `ks_scrambler`

## Requirements
- R1: During and right after synchronous reset, the generator state is 0x01 and the output strobe is low.
- R2: When the load strobe is high, the next state is the given seed. A load takes priority over a step in the same cycle. A data bit presented in that cycle is still scrambled with the pre-load top bit.
- R3: Loading a seed of 0x00 sets the state to 0x01.
- R4: On a cycle with the input strobe high and no load, the state becomes {Q6..Q0, Q7^Q5^Q4^Q3}. In this value, bit 7 is the most significant bit and the new bit enters at bit 0.
- R5: On a cycle with neither the input strobe nor a load, the state does not change.
- R6: If the input strobe is high in a cycle, the next cycle has the output strobe high and out_bit equal to in_bit XOR Q7 of that cycle. If the input strobe is low, the next cycle has the output strobe low.
- R7: From any nonzero seed, the state returns to the seed after exactly 255 steps, with no state repeated before that.
- R8: Two instances loaded with the same seed, with the second fed the first's output stream, reproduce the original input bits in order.
- R9: The state is never 0x00 outside reset.
- R10: gen_state presents Q7..Q0 with Q7 at bit 7, and bit 7 is the keystream bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load strobe for the seed |
| seed_val | input | 8 | Seed value; 0x00 is mapped to 0x01 |
| in_valid | input | 1 | Input data strobe; advances the generator |
| in_bit | input | 1 | Input data bit |
| out_valid | output | 1 | Output data strobe, one cycle after in_valid |
| out_bit | output | 1 | Scrambled (or unscrambled) bit |
| gen_state | output | 8 | Parallel generator state Q7..Q0 |

## Verification
The assertions assume that reset is high at time zero, so every earlier value they compare was produced by a defined register. They also assume that the input strobe, the load strobe and the data lines are never unknown. The bench drives every input from the first cycle and changes them only on the falling edge. It seeds both instances in the same cycle, only while the decoding instance receives no valid bits, so their keystreams stay aligned.

// File: rtl/ks_pkg.sv
package ks_pkg;
    localparam int unsigned KS_W = 8;
    localparam logic [KS_W-1:0] KS_TAPS = 8'hB8;   // Q7, Q5, Q4, Q3
    localparam logic [KS_W-1:0] KS_SAFE = 8'h01;   // reset and zero-seed value

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;
endpackage

// File: rtl/ks_keygen.sv
module ks_keygen #(
    parameter int unsigned       W    = ks_pkg::KS_W,
    parameter logic [W-1:0]      TAPS = ks_pkg::KS_TAPS,
    parameter logic [W-1:0]      SAFE = ks_pkg::KS_SAFE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         adv,
    output logic [W-1:0] q,
    output logic         key_bit
);
    logic [W-1:0] seed_fix;
    logic [W-1:0] q_next;
    logic         fb;

    always_comb begin
        seed_fix = (seed == '0) ? SAFE : seed;
        fb       = ^(q & TAPS);
        q_next   = {q[W-2:0], fb};
    end

    always_ff @(posedge clk) begin
        if (rst)       q <= SAFE;
        else if (load) q <= seed_fix;
        else if (adv)  q <= q_next;
    end

    assign key_bit = q[W-1];

    p_nonzero_r9: assert property (@(posedge clk) disable iff (rst) q != '0);
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (load && seed != '0) |=> q == $past(seed));
    p_zero_seed_r3: assert property (@(posedge clk) disable iff (rst)
        (load && seed == '0) |=> q == SAFE);
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(q));
    p_shift_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && adv) |=> q[W-1:1] == $past(q[W-2:0]));
endmodule

// File: rtl/ks_mix.sv
module ks_mix
    import ks_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    input  logic key_bit,
    output logic out_valid,
    output logic out_bit
);
    slot_e slot_q, slot_d;

    always_ff @(posedge clk) begin
        if (rst) slot_q <= SLOT_EMPTY;
        else     slot_q <= slot_d;
    end

    always_comb begin
        slot_d = slot_q;
        unique case (slot_q)
            SLOT_EMPTY: slot_d = in_valid ? SLOT_FULL : SLOT_EMPTY;  // accept
            SLOT_FULL:  slot_d = in_valid ? SLOT_FULL : SLOT_EMPTY;  // stream / drain
            default:    slot_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           out_bit <= 1'b0;
        else if (in_valid) out_bit <= in_bit ^ key_bit;
    end

    assign out_valid = (slot_q == SLOT_FULL);

    p_rst_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);
    p_valid_follows_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_drops_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/ks_scrambler.sv
module ks_scrambler #(
    parameter int unsigned W = ks_pkg::KS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seed_load,
    input  logic [W-1:0] seed_val,
    input  logic         in_valid,
    input  logic         in_bit,
    output logic         out_valid,
    output logic         out_bit,
    output logic [W-1:0] gen_state
);
    logic key_bit;

    ks_keygen #(.W(W)) u_keygen (
        .clk     (clk),
        .rst     (rst),
        .load    (seed_load),
        .seed    (seed_val),
        .adv     (in_valid),
        .q       (gen_state),
        .key_bit (key_bit)
    );

    ks_mix u_mix (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .key_bit   (key_bit),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    p_msb_key_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_bit == ($past(in_bit) ^ $past(gen_state[W-1])));
endmodule

// File: tb/tb_ks_scrambler.sv
module tb_ks_scrambler;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic seed_load = 1'b0, d_load = 1'b0;
    logic [7:0] seed_val = 8'h00, d_seed = 8'h00;
    logic in_valid = 1'b0, in_bit = 1'b0;
    logic out_valid, out_bit, d_out_valid, d_out_bit;
    logic [7:0] gen_state, d_state;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_state;
    logic pt [0:1023];
    int wr_i = 0;
    int rd_i = 0;

    always #4 clk = ~clk;  // 125 MHz

    ks_scrambler dut (.clk(clk), .rst(rst), .seed_load(seed_load), .seed_val(seed_val),
        .in_valid(in_valid), .in_bit(in_bit), .out_valid(out_valid), .out_bit(out_bit),
        .gen_state(gen_state));

    ks_scrambler dec (.clk(clk), .rst(rst), .seed_load(d_load), .seed_val(d_seed),
        .in_valid(out_valid), .in_bit(out_bit), .out_valid(d_out_valid), .out_bit(d_out_bit),
        .gen_state(d_state));

    function automatic logic [7:0] step_of(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a falling edge; drives, waits one edge, checks at the next falling edge
    task automatic cycle(input logic ld, input logic [7:0] sd, input logic v, input logic b);
        logic exp_bit;
        seed_load = ld; seed_val = sd; in_valid = v; in_bit = b;
        exp_bit = b ^ m_state[7];
        if (ld)     m_state = (sd == 8'h00) ? 8'h01 : sd;
        else if (v) m_state = step_of(m_state);
        @(negedge clk);
        chk("R4/R5/R2 state", gen_state, m_state);
        chk("R6 out_valid", out_valid, v);
        if (v) chk("R6/R10 out_bit", out_bit, exp_bit);
        if (d_out_valid && rd_i < wr_i) begin
            chk("R8 round trip", d_out_bit, pt[rd_i]);
            rd_i++;
        end
        seed_load = 1'b0; in_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        chk("R1 reset state", gen_state, 8'h01);
        chk("R1 reset out_valid", out_valid, 1'b0);
        rst = 1'b0;
        m_state = 8'h01;
        @(negedge clk);
        chk("R1 after reset", gen_state, 8'h01);

        // R3 zero seed
        cycle(1'b1, 8'h00, 1'b0, 1'b0);
        chk("R3 zero seed", gen_state, 8'h01);
        // R2 load with simultaneous data: load wins, bit uses old Q7
        cycle(1'b1, 8'hC3, 1'b0, 1'b0);
        cycle(1'b1, 8'h5A, 1'b1, 1'b1);
        chk("R2 load priority", gen_state, 8'h5A);
        // R5 hold
        cycle(1'b0, 8'hFF, 1'b0, 1'b1);
        cycle(1'b0, 8'h00, 1'b0, 1'b0);

        // R7 period and no repeats, several seeds; R9 never zero
        foreach (m_state[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [7:0] sd;
            logic seen [0:255];
            int rep;
            sd = (k == 0) ? 8'h01 : (k == 1) ? 8'h5A : (k == 2) ? 8'hFF : 8'h80;
            for (int j = 0; j < 256; j++) seen[j] = 1'b0;
            rep = 0;
            cycle(1'b1, sd, 1'b0, 1'b0);
            seen[gen_state] = 1'b1;
            for (int n = 1; n <= 255; n++) begin
                cycle(1'b0, 8'h00, 1'b1, 1'($urandom));
                if (n < 255) begin
                    if (seen[gen_state] || gen_state == 8'h00) rep++;
                    seen[gen_state] = 1'b1;
                end
            end
            chk("R7 no repeat / R9 nonzero", rep, 0);
            chk("R7 period 255", gen_state, sd);
        end

        // R8 round trip with two instances, random data and gaps
        cycle(1'b0, 8'h00, 1'b0, 1'b0);
        cycle(1'b0, 8'h00, 1'b0, 1'b0);
        d_load = 1'b1; d_seed = 8'hA7;
        cycle(1'b1, 8'hA7, 1'b0, 1'b0);
        d_load = 1'b0;
        chk("R8 same seed", d_state, gen_state);
        for (int n = 0; n < 600; n++) begin
            logic v, b;
            v = ($urandom % 4) != 0;
            b = 1'($urandom);
            if (v) begin pt[wr_i] = b; wr_i++; end
            cycle(1'b0, 8'h00, v, b);
        end
        cycle(1'b0, 8'h00, 1'b0, 1'b0);
        cycle(1'b0, 8'h00, 1'b0, 1'b0);
        chk("R8 all bits recovered", rd_i, wr_i);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule